// File: doc/BRIEF.md
# Interlocked Synchronous Rectifier Gate Sequencer

This block drives the gates of two synchronous-rectifier switches that sit on the two halves of a centre-tapped secondary. Each switch has a digitized drain-source sense path that delivers four comparator bits per clock: an arm threshold, a pre-trigger threshold, a conduction (turn-on) threshold and a near-zero-current (turn-off) threshold. Two state machines run side by side, one per switch. A switch is first armed by its partner, then pre-triggered, then switched on once its body diode conducts, and released when its current nears zero.

The two channels are cross-coupled. A rising crossing of one channel's arm comparator arms the other channel. A shared turn-on arbiter guarantees that the two gate commands are never high together, and that a gate only rises after the opposite gate has been low for at least one clock. A supply-good input, low during undervoltage, forces both machines to idle and both gates low. Each channel's state is exposed as a 2-bit debug code.

Top module: `srgs_top`

## Requirements
- R1: While `rst` is high at a clock edge, both channels return to IDLE (debug code 0) and both bits of `gate` are 0.
- R2: A 0-to-1 transition of `arm_cmp[k]` between two consecutive samples moves the other channel from IDLE to ARMED (code 1) on that edge. A level held high, including one held through reset, arms nothing.
- R3: A 1-to-0 transition of `pretrig_cmp[k]` moves channel k from ARMED to PRETRIG (code 2). The same transition has no effect on a channel in IDLE, and a steady low level has no effect.
- R4: A channel in PRETRIG whose `on_cmp` bit is high moves to ON (code 3) and raises its `gate` bit on that edge, provided the opposite channel is not in ON.
- R5: A channel in ON whose `off_cmp` bit is high returns to IDLE and drops its `gate` bit on that edge.
- R6: A channel that has returned to IDLE ignores pre-trigger and turn-on inputs until a fresh arm event from the opposite channel.
- R7: `gate[0]` and `gate[1]` are never both high. A turn-on request made while the opposite channel is in ON is held in PRETRIG, so a gate rises only after the other gate was low in the previous cycle. When both channels qualify on the same edge, channel 0 turns on and channel 1 stays in PRETRIG.
- R8: While `supply_ok` is low, both channels go to IDLE on the next edge and both gates are low, and arm events are ignored. The edge detectors keep sampling, so an arm level still high when `supply_ok` returns arms nothing.
- R9: `dbg_state0` and `dbg_state1` carry the channel states with IDLE=0, ARMED=1, PRETRIG=2, ON=3, and `gate[k]` is 1 exactly when channel k is in ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply above lockout level; low forces both gates off |
| arm_cmp | input | 2 | Arm-threshold comparator bit per channel |
| pretrig_cmp | input | 2 | Pre-trigger comparator bit per channel |
| on_cmp | input | 2 | Body-diode conduction comparator bit per channel |
| off_cmp | input | 2 | Near-zero-current comparator bit per channel |
| gate | output | 2 | Gate command per channel |
| dbg_state0 | output | 2 | Channel 0 state code |
| dbg_state1 | output | 2 | Channel 1 state code |

## Verification
Every state register drives a port directly through the debug codes, and the gate bits are decoded from the same register. A wrong transition therefore shows on the port one clock after the input edge that caused it, with no latency to hide it. Faults in the arbiter or the edge memory show up later: as both gates high or a gate rising straight after the other fell, or as a channel that arms from a held level after reset or lockout. The bench steps a reference model each cycle over a long random run and compares the full state every cycle, so such a fault is caught within a clock of its first effect.

// File: rtl/srgs_pkg.sv
package srgs_pkg;

    localparam int NCH  = 2;
    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PRETRIG = 2'd2,
        ST_ON      = 2'd3
    } chan_state_t;

    typedef struct packed {
        logic arm_evt;
        logic pt_evt;
        logic on_lvl;
        logic off_lvl;
    } chan_in_t;

    function automatic logic is_conducting(chan_state_t s);
        return s == ST_ON;
    endfunction

endpackage

// File: rtl/srgs_edge_det.sv
module srgs_edge_det #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;
endmodule

// File: rtl/srgs_chan_fsm.sv
module srgs_chan_fsm
    import srgs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  chan_in_t    cin,
    input  logic        grant,
    output chan_state_t state,
    output logic        want_on,
    output logic        conducting
);
    chan_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:    if (cin.arm_evt) st_d = ST_ARMED;
                ST_ARMED:   if (cin.pt_evt)  st_d = ST_PRETRIG;
                ST_PRETRIG: if (grant)       st_d = ST_ON;
                ST_ON:      if (cin.off_lvl) st_d = ST_IDLE;
                default:                     st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state      = st_q;
    assign want_on    = (st_q == ST_PRETRIG) && cin.on_lvl;
    assign conducting = is_conducting(st_q);
endmodule

// File: rtl/srgs_turnon_arb.sv
module srgs_turnon_arb
    import srgs_pkg::*;
(
    input  logic [NCH-1:0] want_on,
    input  logic [NCH-1:0] conducting,
    output logic [NCH-1:0] grant
);
    // Channel 0 has priority on a simultaneous request.
    always_comb begin
        grant[0] = want_on[0] && !conducting[1];
        grant[1] = want_on[1] && !conducting[0] && !grant[0];
    end
endmodule

// File: rtl/srgs_top.sv
module srgs_top
    import srgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic [1:0] arm_cmp,
    input  logic [1:0] pretrig_cmp,
    input  logic [1:0] on_cmp,
    input  logic [1:0] off_cmp,
    output logic [1:0] gate,
    output logic [1:0] dbg_state0,
    output logic [1:0] dbg_state1
);
    logic [NCH-1:0] arm_rise, arm_fall_unused;
    logic [NCH-1:0] pt_rise_unused, pt_fall;
    logic [NCH-1:0] want_on, conducting, grant;
    chan_state_t    st [NCH];

    // Arm detector remembers "high" after reset so a held level arms nothing.
    srgs_edge_det #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_arm_edge (
        .clk(clk), .rst(rst), .din(arm_cmp),
        .rise(arm_rise), .fall(arm_fall_unused)
    );

    srgs_edge_det #(.W(NCH), .RST_VAL({NCH{1'b0}})) u_pt_edge (
        .clk(clk), .rst(rst), .din(pretrig_cmp),
        .rise(pt_rise_unused), .fall(pt_fall)
    );

    srgs_turnon_arb u_arb (
        .want_on(want_on), .conducting(conducting), .grant(grant)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int OTH = NCH - 1 - g;
        chan_in_t cin;
        assign cin.arm_evt = arm_rise[OTH];
        assign cin.pt_evt  = pt_fall[g];
        assign cin.on_lvl  = on_cmp[g];
        assign cin.off_lvl = off_cmp[g];

        srgs_chan_fsm u_fsm (
            .clk(clk), .rst(rst), .enable(supply_ok), .cin(cin),
            .grant(grant[g]), .state(st[g]),
            .want_on(want_on[g]), .conducting(conducting[g])
        );
    end

    assign gate       = conducting;
    assign dbg_state0 = st[0];
    assign dbg_state1 = st[1];
endmodule

// File: rtl/srgs_checker.sv
module srgs_checker (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic [1:0] off_cmp,
    input logic [1:0] gate,
    input logic [1:0] dbg_state0,
    input logic [1:0] dbg_state1
);
    a_r7_never_both: assert property (@(posedge clk) disable iff (rst)
        !(gate[0] && gate[1]));

    a_r7_gap_ch0: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[0]) |-> !$past(gate[1]));

    a_r7_gap_ch1: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[1]) |-> !$past(gate[0]));

    a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (gate == 2'b00 && dbg_state0 == 2'd0 && dbg_state1 == 2'd0));

    a_r5_release0: assert property (@(posedge clk) disable iff (rst)
        (dbg_state0 == 2'd3 && off_cmp[0]) |=> !gate[0]);

    a_r4_from_pretrig0: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[0]) |-> ($past(dbg_state0) == 2'd2));

    a_r9_gate_code1: assert property (@(posedge clk) disable iff (rst)
        gate[1] == (dbg_state1 == 2'd3));
endmodule

bind srgs_top srgs_checker u_chk (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .off_cmp(off_cmp),
    .gate(gate), .dbg_state0(dbg_state0), .dbg_state1(dbg_state1)
);

// File: tb/srgs_top_tb.sv
`timescale 1ns/1ps
module srgs_top_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok;
    logic [1:0] arm_cmp, pretrig_cmp, on_cmp, off_cmp;
    logic [1:0] gate, dbg_state0, dbg_state1;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    // reference model state
    logic [1:0] m_st [2];
    logic [1:0] m_parm, m_ppt;

    always #4 clk = ~clk;

    srgs_top u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .arm_cmp(arm_cmp), .pretrig_cmp(pretrig_cmp),
        .on_cmp(on_cmp), .off_cmp(off_cmp),
        .gate(gate), .dbg_state0(dbg_state0), .dbg_state1(dbg_state1)
    );

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got %b expected %b (gate,st1,st0)", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pack_out(logic [1:0] g, logic [1:0] s1, logic [1:0] s0);
        return {g, s1, s0};
    endfunction

    function automatic logic [5:0] model_out();
        logic [1:0] g;
        g[0] = (m_st[0] == 2'd3);
        g[1] = (m_st[1] == 2'd3);
        return {g, m_st[1], m_st[0]};
    endfunction

    task automatic model_reset();
        m_st[0] = 2'd0; m_st[1] = 2'd0;
        m_parm  = 2'b11; m_ppt = 2'b00;
    endtask

    task automatic model_step();
        logic [1:0] ns [2];
        logic [1:0] want, gr;
        for (int k = 0; k < 2; k++) begin
            ns[k] = m_st[k];
            want[k] = (m_st[k] == 2'd2) && on_cmp[k];
        end
        gr[0] = want[0] && (m_st[1] != 2'd3);
        gr[1] = want[1] && (m_st[0] != 2'd3) && !gr[0];
        for (int k = 0; k < 2; k++) begin
            if (!supply_ok) ns[k] = 2'd0;
            else if (m_st[k] == 2'd0 && arm_cmp[1-k] && !m_parm[1-k]) ns[k] = 2'd1;
            else if (m_st[k] == 2'd1 && !pretrig_cmp[k] && m_ppt[k]) ns[k] = 2'd2;
            else if (m_st[k] == 2'd2 && gr[k]) ns[k] = 2'd3;
            else if (m_st[k] == 2'd3 && off_cmp[k]) ns[k] = 2'd0;
        end
        m_st[0] = ns[0]; m_st[1] = ns[1];
        m_parm = arm_cmp; m_ppt = pretrig_cmp;
    endtask

    // called at a negedge: drive, pass one posedge, return at next negedge
    task automatic step(logic s, logic [1:0] a, logic [1:0] p, logic [1:0] o, logic [1:0] f);
        supply_ok = s; arm_cmp = a; pretrig_cmp = p; on_cmp = o; off_cmp = f;
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51A7));
        rst = 1; supply_ok = 1; arm_cmp = 2'b11; pretrig_cmp = 0; on_cmp = 0; off_cmp = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", pack_out(gate, dbg_state1, dbg_state0), 6'b0);
        rst = 0;

        // R2: arm level held through reset does nothing
        step(1, 2'b11, 2'b00, 2'b00, 2'b00);
        check("R2 held level", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);
        step(1, 2'b00, 2'b00, 2'b00, 2'b00);
        step(1, 2'b01, 2'b00, 2'b00, 2'b00);
        check("R2 arm ch1 from ch0", pack_out(gate, dbg_state1, dbg_state0), 6'b00_01_00);
        step(1, 2'b01, 2'b11, 2'b00, 2'b00);
        check("R3 rising pretrig ignored", pack_out(gate, dbg_state1, dbg_state0), 6'b00_01_00);
        step(1, 2'b01, 2'b00, 2'b00, 2'b00);
        check("R3 pretrig fall, idle ch0 ignores", pack_out(gate, dbg_state1, dbg_state0), 6'b00_10_00);
        step(1, 2'b01, 2'b00, 2'b10, 2'b00);
        check("R4 ch1 on", pack_out(gate, dbg_state1, dbg_state0), 6'b10_11_00);
        step(1, 2'b11, 2'b00, 2'b10, 2'b00);
        check("R2 arm ch0 from ch1", pack_out(gate, dbg_state1, dbg_state0), 6'b10_11_01);
        step(1, 2'b11, 2'b01, 2'b10, 2'b00);
        step(1, 2'b11, 2'b00, 2'b10, 2'b00);
        check("R3 ch0 pretrig", pack_out(gate, dbg_state1, dbg_state0), 6'b10_11_10);
        step(1, 2'b11, 2'b00, 2'b11, 2'b00);
        check("R7 blocked while other on", pack_out(gate, dbg_state1, dbg_state0), 6'b10_11_10);
        step(1, 2'b11, 2'b00, 2'b11, 2'b10);
        check("R5 ch1 off, R7 gap", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_10);
        step(1, 2'b11, 2'b00, 2'b01, 2'b00);
        check("R7 ch0 on after gap", pack_out(gate, dbg_state1, dbg_state0), 6'b01_00_11);
        step(1, 2'b11, 2'b00, 2'b01, 2'b01);
        check("R5 ch0 off", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);
        step(1, 2'b11, 2'b01, 2'b01, 2'b00);
        step(1, 2'b11, 2'b00, 2'b01, 2'b00);
        check("R6 no rearm", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);
        step(1, 2'b00, 2'b00, 2'b00, 2'b00);
        step(1, 2'b11, 2'b00, 2'b00, 2'b00);
        check("R2 both armed", pack_out(gate, dbg_state1, dbg_state0), 6'b00_01_01);
        step(1, 2'b11, 2'b11, 2'b00, 2'b00);
        step(1, 2'b11, 2'b00, 2'b00, 2'b00);
        check("R3 both pretrig", pack_out(gate, dbg_state1, dbg_state0), 6'b00_10_10);
        step(1, 2'b11, 2'b00, 2'b11, 2'b00);
        check("R7 tie goes to ch0", pack_out(gate, dbg_state1, dbg_state0), 6'b01_10_11);
        step(0, 2'b11, 2'b00, 2'b11, 2'b00);
        check("R8 lockout clears", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);
        step(0, 2'b00, 2'b00, 2'b00, 2'b00);
        step(0, 2'b11, 2'b00, 2'b00, 2'b00);
        check("R8 arm ignored in lockout", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);
        step(1, 2'b11, 2'b00, 2'b00, 2'b00);
        check("R8 held arm after lockout", pack_out(gate, dbg_state1, dbg_state0), 6'b00_00_00);

        // random phase against the reference model (R9 encodings, R7 interlock)
        for (int i = 0; i < 4000; i++) begin
            logic s;
            s = ($urandom % 40) != 0;
            step(s, 2'($urandom), 2'($urandom), 2'($urandom), 2'(($urandom % 3 == 0) ? $urandom : 0));
            check("R9 random vs model", pack_out(gate, dbg_state1, dbg_state0), model_out());
            if (gate == 2'b11) check("R7 random both gates", {4'b0, gate}, 6'b0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule